// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block watches sixteen interrupt lines, each fed from one pin of a group of general-purpose I/O ports. Line n always takes pin n, and a 4-bit source field for that line picks the port that supplies it. Each sampled line passes through a two-flop synchronizer and then an edge detector. The detector is armed for rising edges, falling edges or both.

A detected rising edge sets that line's rising pending flag, and a detected falling edge sets its falling pending flag. Software clears each flag by writing 1 to it. A per-line interrupt mask passes the pending state to a level interrupt output. A separate per-line event mask passes each detection straight to a one-cycle event pulse. A release write takes lines back to their unconfigured state.

Configuration arrives over a simple write strobe with a 4-bit address and 32-bit data. Decoding a write into its target register is the block's only control step. The target kinds are the source-select slots, the rising enable, the falling enable, the interrupt mask, the event mask, the two clear strobes and the release strobe. Each kind is handled by one branch of a single case statement, and a write to an unused address changes nothing.

Top module: `edge_irq_ctrl`

## Requirements
- R1: Line n is driven by pin n of the port whose index sits in the 4-bit field at write address n/4 (0 to 3), data bits [8*(n mod 4)+3 : 8*(n mod 4)]. Port p's pins occupy `port_pins[p*16 +: 16]`.
- R2: A source index equal to or above the number of ports (4 by default) connects a line to a constant low, so no edge is ever detected on that line.
- R3: Data bit n written to address 4 arms rising-edge detection on line n. Data bit n written to address 5 arms falling-edge detection on line n. Both may be armed at once.
- R4: An armed rising edge sets `pend_rise[n]`, and an armed falling edge sets `pend_fall[n]`. Each flag is visible after the third rising clock edge that follows the pin change, and the two flags are independent.
- R5: Writing 1 to bit n at address 8 clears `pend_rise[n]`. Writing 1 to bit n at address 9 clears `pend_fall[n]`. Bits written as 0 leave their flags unchanged.
- R6: When a clear and a new armed edge hit the same flag in the same cycle, the flag stays set.
- R7: `irq[n]` equals (`pend_rise[n]` OR `pend_fall[n]`) AND the interrupt-mask bit n, which is written at address 6.
- R8: `evt[n]` is high for exactly one cycle, in the cycle before the pending flag sets, when an armed edge is detected and event-mask bit n (address 7) is 1. `evt[n]` does not depend on the interrupt mask.
- R9: Writing 1 to bit n at address 10 clears line n's source field, both trigger enables and both masks. The line's pending flags are kept.
- R10: After reset, all configuration and pending state is zero, and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_pins | input | 64 | Pins of all ports, port p in bits [p*16+15:p*16] |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Write data |
| pend_rise | output | 16 | Rising-edge pending flags |
| pend_fall | output | 16 | Falling-edge pending flags |
| irq | output | 16 | Masked interrupt request, one per line |
| evt | output | 16 | Masked one-cycle event pulse, one per line |

## Verification
The hardest case to reach from the ports is a clear write that arrives in the same clock cycle as a new detection on the same flag. Reaching it means aligning the write strobe with the output of the synchronizer, which the bench cannot see. The stimulus changes the pin on a falling clock edge and waits two falling edges. It then presents the clear so that it is sampled at the same rising edge as the detection. Source routing is swept over every line against every port by rotating the select fields through four rounds and raising one port at a time.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;
    localparam int SLOT_W  = 8;

    typedef enum logic [ADDR_W-1:0] {
        K_RISE = 4'd4,
        K_FALL = 4'd5,
        K_IMSK = 4'd6,
        K_EMSK = 4'd7,
        K_CLRR = 4'd8,
        K_CLRF = 4'd9,
        K_REL  = 4'd10
    } cfg_kind_t;
endpackage

// File: rtl/eic_cfg_regs.sv
module eic_cfg_regs
    import eic_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int SELW   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NLINES*SELW-1:0]   sel_flat,
    output logic [NLINES-1:0]        rise_en,
    output logic [NLINES-1:0]        fall_en,
    output logic [NLINES-1:0]        imask,
    output logic [NLINES-1:0]        emask,
    output logic [NLINES-1:0]        clr_rise,
    output logic [NLINES-1:0]        clr_fall
);
    localparam int LPR     = DATA_W / SLOT_W;
    localparam int NSELREG = (NLINES + LPR - 1) / LPR;

    cfg_kind_t               kind;
    logic [SELW-1:0]         sel_q [NLINES];
    logic [NLINES-1:0]       wmask;
    logic                    unused_bits;

    assign kind        = cfg_kind_t'(wr_addr);
    assign wmask       = wr_data[NLINES-1:0];
    assign unused_bits = &{1'b0, wr_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            imask   <= '0;
            emask   <= '0;
            for (int n = 0; n < NLINES; n++) sel_q[n] <= '0;
        end else if (wr_en) begin
            unique case (kind)
                K_RISE: rise_en <= wmask;
                K_FALL: fall_en <= wmask;
                K_IMSK: imask   <= wmask;
                K_EMSK: emask   <= wmask;
                K_CLRR, K_CLRF: ;
                K_REL: begin
                    rise_en <= rise_en & ~wmask;
                    fall_en <= fall_en & ~wmask;
                    imask   <= imask   & ~wmask;
                    emask   <= emask   & ~wmask;
                    for (int n = 0; n < NLINES; n++)
                        if (wmask[n]) sel_q[n] <= '0;
                end
                default: begin
                    for (int g = 0; g < NSELREG; g++)
                        if (wr_addr == ADDR_W'(g))
                            for (int j = 0; j < LPR; j++)
                                if (g*LPR + j < NLINES)
                                    sel_q[g*LPR + j] <= wr_data[SLOT_W*j +: SELW];
                end
            endcase
        end
    end

    always_comb begin
        clr_rise = '0;
        clr_fall = '0;
        if (wr_en && kind == K_CLRR) clr_rise = wmask;
        if (wr_en && kind == K_CLRF) clr_fall = wmask;
    end

    for (genvar n = 0; n < NLINES; n++) begin : g_sel
        assign sel_flat[n*SELW +: SELW] = sel_q[n];
    end

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == K_REL) |=>
        (((rise_en | fall_en | imask | emask) & $past(wmask)) == '0)); // R9
endmodule

// File: rtl/eic_line.sv
module eic_line #(
    parameter int NPORTS = 4,
    parameter int SELW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] port_bits,
    input  logic [SELW-1:0]   sel,
    input  logic              rise_en,
    input  logic              fall_en,
    input  logic              imask,
    input  logic              emask,
    input  logic              clr_r,
    input  logic              clr_f,
    output logic              pend_r,
    output logic              pend_f,
    output logic              irq,
    output logic              evt
);
    logic       src;
    logic [2:0] sync_q;
    logic       rise_hit;
    logic       fall_hit;

    always_comb begin
        src = 1'b0;
        for (int p = 0; p < NPORTS; p++)
            if (sel == SELW'(p)) src = port_bits[p];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], src};
    end

    assign rise_hit = rise_en &  sync_q[1] & ~sync_q[2];
    assign fall_hit = fall_en & ~sync_q[1] &  sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_r <= 1'b0;
            pend_f <= 1'b0;
        end else begin
            pend_r <= (pend_r & ~clr_r) | rise_hit;
            pend_f <= (pend_f & ~clr_f) | fall_hit;
        end
    end

    always_comb begin
        irq = (pend_r | pend_f) & imask;
        evt = (rise_hit | fall_hit) & emask;
    end

    AST_PEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_r) |-> $past(rise_en && sync_q[1])); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_r && !rise_hit) |=> !pend_r); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        fall_hit |=> pend_f); // R6
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_hit |=> !rise_hit); // R8
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int NPORTS = 4,
    parameter int SELW   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPORTS*NLINES-1:0] port_pins,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NLINES-1:0]        pend_rise,
    output logic [NLINES-1:0]        pend_fall,
    output logic [NLINES-1:0]        irq,
    output logic [NLINES-1:0]        evt
);
    logic [NLINES*SELW-1:0] sel_flat;
    logic [NLINES-1:0]      rise_en, fall_en, imask, emask, clr_rise, clr_fall;

    eic_cfg_regs #(.NLINES(NLINES), .SELW(SELW)) i_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sel_flat(sel_flat), .rise_en(rise_en),
        .fall_en(fall_en), .imask(imask), .emask(emask),
        .clr_rise(clr_rise), .clr_fall(clr_fall)
    );

    for (genvar n = 0; n < NLINES; n++) begin : g_line
        logic [NPORTS-1:0] col;
        for (genvar p = 0; p < NPORTS; p++) begin : g_col
            assign col[p] = port_pins[p*NLINES + n];
        end
        eic_line #(.NPORTS(NPORTS), .SELW(SELW)) i_line (
            .clk(clk), .rst_n(rst_n), .port_bits(col),
            .sel(sel_flat[n*SELW +: SELW]),
            .rise_en(rise_en[n]), .fall_en(fall_en[n]),
            .imask(imask[n]), .emask(emask[n]),
            .clr_r(clr_rise[n]), .clr_f(clr_fall[n]),
            .pend_r(pend_rise[n]), .pend_f(pend_fall[n]),
            .irq(irq[n]), .evt(evt[n])
        );
    end

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~(pend_rise | pend_fall)) == '0)); // R7
endmodule

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/1ps
module test_edge_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] port_pins = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] pend_rise, pend_fall, irq, evt;

    int checks = 0;
    int fails  = 0;
    logic [15:0] evt_acc = '0;
    int evt_cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    edge_irq_ctrl i_edge_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pend_rise(pend_rise),
        .pend_fall(pend_fall), .irq(irq), .evt(evt)
    );

    always @(negedge clk) begin
        evt_acc <= evt_acc | evt;
        if (evt != '0) evt_cycles <= evt_cycles + 1;
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(4'd8, 32'hFFFF_FFFF);
        wr(4'd9, 32'hFFFF_FFFF);
    endtask

    task automatic sel_all(input int k);
        for (int g = 0; g < 4; g++) begin
            logic [31:0] d;
            d = '0;
            for (int j = 0; j < 4; j++) d[8*j +: 4] = 4'((4*g + j + k) % 4);
            wr(4'(g), d);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 pend_rise", pend_rise, 16'h0);
        chk("R10 pend_fall", pend_fall, 16'h0);
        chk("R10 irq", irq, 16'h0);
        chk("R10 evt", evt, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: rotate every line over every port
        wr(4'd4, 32'h0000_FFFF);
        for (int k = 0; k < 4; k++) begin
            sel_all(k);
            clear_all();
            for (int q = 0; q < 4; q++) begin
                logic [15:0] exp;
                exp = '0;
                for (int n = 0; n < 16; n++) if ((n + k) % 4 == q) exp[n] = 1'b1;
                port_pins[q*16 +: 16] = 16'hFFFF;
                settle();
                chk("R1 route", pend_rise, exp);
                port_pins[q*16 +: 16] = 16'h0;
                settle();
                clear_all();
            end
        end

        // R3/R4: edge selection
        for (int g = 0; g < 4; g++) wr(4'(g), 32'h0);
        wr(4'd4, 32'h0000_3333);
        wr(4'd5, 32'h0000_5555);
        clear_all();
        port_pins[15:0] = 16'hFFFF;
        settle();
        chk("R3 rise only", pend_rise, 16'h3333);
        chk("R4 fall untouched", pend_fall, 16'h0);
        port_pins[15:0] = 16'h0;
        settle();
        chk("R4 fall flags", pend_fall, 16'h5555);
        chk("R4 rise kept", pend_rise, 16'h3333);

        // R7
        wr(4'd6, 32'h0000_00FF);
        @(negedge clk);
        chk("R7 irq", irq, 16'h0077);

        // R5
        wr(4'd8, 32'h0000_0030);
        chk("R5 clear rise", pend_rise, 16'h3303);
        wr(4'd9, 32'h0000_FFFF);
        chk("R5 clear fall", pend_fall, 16'h0);

        // R8
        clear_all();
        wr(4'd6, 32'h0);
        wr(4'd7, 32'h0000_0F0F);
        evt_acc = '0; evt_cycles = 0;
        port_pins[15:0] = 16'hFFFF;
        settle();
        chk("R8 evt rise lines", evt_acc, 16'h0303);
        chk("R8 evt width", 16'(evt_cycles), 16'd1);
        chk("R8 irq masked", irq, 16'h0);
        evt_acc = '0; evt_cycles = 0;
        port_pins[15:0] = 16'h0;
        settle();
        chk("R8 evt fall lines", evt_acc, 16'h0505);
        chk("R8 evt fall width", 16'(evt_cycles), 16'd1);

        // R6: clear on the detection cycle
        wr(4'd7, 32'h0);
        wr(4'd5, 32'h0);
        wr(4'd4, 32'h0000_FFFF);
        clear_all();
        port_pins[6:5] = 2'b11;
        settle();
        port_pins[6:5] = 2'b00;
        settle();
        chk("R6 setup", pend_rise, 16'h0060);
        port_pins[5] = 1'b1;
        @(negedge clk);
        wr(4'd8, 32'h0000_0060);
        settle();
        chk("R6 set wins", pend_rise, 16'h0020);
        port_pins[5] = 1'b0;
        settle();

        // R2: out-of-range source
        wr(4'd0, 32'h0009_0000);
        clear_all();
        port_pins = '1;
        settle();
        chk("R2 no source", pend_rise, 16'hFFFB);

        // R9: release lines 0 and 1
        wr(4'd6, 32'h0000_FFFF);
        wr(4'd10, 32'h0000_0003);
        @(negedge clk);
        chk("R9 irq masked off", irq, 16'hFFF8);
        chk("R9 pending kept", pend_rise, 16'hFFFB);
        clear_all();
        port_pins = '0;
        settle();
        port_pins = '1;
        settle();
        chk("R9 triggers off", pend_rise, 16'hFFF8);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule